// File: doc/BRIEF.md
# Outbound Interrupt Aggregation Controller

This block gathers a large set of internal level-sensitive interrupt requests and funnels them onto a small number of outbound interrupt lines. A typical use is a device that raises a single interrupt pin towards a host. Every request line feeds a latched pending flag. The pending flag is qualified by a per-source enable. A routing matrix then decides which outbound lines each source drives.

Host software sees a 32-bit register bus. Sources are grouped into 32-bit words ("banks"), with one register per bank for each of these: pending flags, enable readback, enable-clear and enable-set. Each outbound line has one routing word per bank. Each outbound line also has a read-only word per bank that shows the pending, enabled and routed sources, so an interrupt handler can find its work with one read per bank. Enables change only through the atomic set and clear registers, so a read-modify-write race between software agents cannot occur.

Top module: `irqagg_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every pending, enable and routing bit is zero, every register reads zero and every outbound line is low.
- R2: A pending bit is set in every cycle its source input is high. It stays set after the source drops, and it reads at 0x30 + 4*bank, with source s at bank s/32 and bit s%32.
- R3: Writing 1s to a pending register clears those bits and 0 bits leave them unchanged. If a source is high in the same cycle its bit is written 1, the bit stays set.
- R4: The enables read at 0x48 + 4*bank. Writing 1s to 0x54 + 4*bank clears the matching enables, writing 1s to 0x60 + 4*bank sets them, 0 bits have no effect, and writes to the readback address are ignored.
- R5: Routing word (destination n, bank b) is read/write at 0x78 + 0x24*b + 4*n, for n = 0..8. It holds its value until it is written.
- R6: Identity word (n, b) at 0xE4 + 0x24*b + 4*n reads pending AND enable AND routing(n, b), and writes to it are ignored.
- R7: Outbound line n goes high one clock edge after any of its identity bits is set, and it stays high until all of them have cleared or been masked.
- R8: Bits 22..31 of bank 2 have no source. They read zero in every register and ignore writes.
- R9: Offsets outside the register set, and offsets that are not word aligned, read zero and ignore writes.
- R10: With sources idle, writing all 1s to a bank's enable-clear register and then all 1s to its pending register leaves that bank with zero enables and zero pending bits, and drops its outbound contributions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 86 | Level-sensitive interrupt requests, active high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| dst_irq | output | 9 | Outbound interrupt lines, active high |

## Verification
The hardest case to reach is a pending-clear write that lands in the same cycle as its source is high, while other sources routed to the same line are enabled or masked. The outbound line must then stay high for exactly the right reason. The stimulus pairs sparse random source patterns with random writes across every register class, so such collisions occur often. A reference model tracks every pending, enable and routing bit, and a random read follows each cycle. Directed steps add the same-cycle collision on purpose, the unused top bits of the last bank, misaligned addresses and the full disable-and-acknowledge sequence.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    parameter int NUM_SRC  = 86;
    parameter int NUM_DST  = 9;
    parameter int WORD_W   = 32;
    parameter int ADDR_W   = 9;
    localparam int NUM_BANK = (NUM_SRC + WORD_W - 1) / WORD_W;
    localparam int BANK_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
    localparam int DST_W    = (NUM_DST > 1) ? $clog2(NUM_DST) : 1;

    localparam logic [ADDR_W-1:0] PEND_BASE = 9'h030;
    localparam logic [ADDR_W-1:0] ENRD_BASE = 9'h048;
    localparam logic [ADDR_W-1:0] ENCL_BASE = 9'h054;
    localparam logic [ADDR_W-1:0] ENST_BASE = 9'h060;
    localparam logic [ADDR_W-1:0] ROUT_BASE = 9'h078;
    localparam logic [ADDR_W-1:0] IDNT_BASE = 9'h0E4;
    localparam logic [ADDR_W-1:0] BANK_STEP = 9'h024;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        RK_NONE, RK_PEND, RK_ENRD, RK_ENCL, RK_ENST, RK_ROUT, RK_IDNT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [BANK_W-1:0] bank;
        logic [DST_W-1:0]  dst;
    } reg_sel_t;

    function automatic word_t bank_valid(input int b);
        int rem;
        rem = NUM_SRC - b * WORD_W;
        if (rem >= WORD_W) return '1;
        if (rem <= 0) return '0;
        return (word_t'(1) << rem) - word_t'(1);
    endfunction

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.bank = '0;
        s.dst  = '0;
        for (int b = 0; b < NUM_BANK; b++) begin
            if (a == PEND_BASE + ADDR_W'(4*b)) begin s.kind = RK_PEND; s.bank = BANK_W'(b); end
            if (a == ENRD_BASE + ADDR_W'(4*b)) begin s.kind = RK_ENRD; s.bank = BANK_W'(b); end
            if (a == ENCL_BASE + ADDR_W'(4*b)) begin s.kind = RK_ENCL; s.bank = BANK_W'(b); end
            if (a == ENST_BASE + ADDR_W'(4*b)) begin s.kind = RK_ENST; s.bank = BANK_W'(b); end
            for (int n = 0; n < NUM_DST; n++) begin
                if (a == ROUT_BASE + ADDR_W'(b) * BANK_STEP + ADDR_W'(4*n)) begin
                    s.kind = RK_ROUT; s.bank = BANK_W'(b); s.dst = DST_W'(n);
                end
                if (a == IDNT_BASE + ADDR_W'(b) * BANK_STEP + ADDR_W'(4*n)) begin
                    s.kind = RK_IDNT; s.bank = BANK_W'(b); s.dst = DST_W'(n);
                end
            end
        end
        return s;
    endfunction
endpackage

// File: rtl/irqagg_bank.sv
module irqagg_bank
    import irqagg_pkg::*;
#(
    parameter int BANK_IDX = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t src_in,
    input  logic  pend_clr_we,
    input  logic  en_clr_we,
    input  logic  en_set_we,
    input  word_t wdata,
    output word_t pending,
    output word_t enable
);
    localparam word_t VALID = bank_valid(BANK_IDX);

    word_t pend_clr, en_clr, en_set, src_v;

    always_comb begin
        src_v    = src_in & VALID;
        pend_clr = pend_clr_we ? wdata : '0;
        en_clr   = en_clr_we   ? wdata : '0;
        en_set   = en_set_we   ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            enable  <= '0;
        end else begin
            pending <= ((pending & ~pend_clr) | src_v) & VALID;
            enable  <= ((enable & ~en_clr) | en_set) & VALID;
        end
    end

    // a high source is latched at the next edge, whatever the write does
    assert_src_latch_R2: assert property (@(posedge clk) disable iff (rst)
        ((src_in & VALID) != '0) |=> ((pending & $past(src_in & VALID)) == $past(src_in & VALID)));

    // a 1 written with the source low clears the bit (R3)
    assert_pend_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_clr_we && ((wdata & ~src_in & VALID) != '0))
        |=> ((pending & $past(wdata & ~src_in & VALID)) == '0));

    assert_enable_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!en_clr_we && !en_set_we) |=> $stable(enable));
endmodule

// File: rtl/irqagg_route.sv
module irqagg_route
    import irqagg_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               map_we,
    input  logic [BANK_W-1:0]                  map_bank,
    input  logic [DST_W-1:0]                   map_dst,
    input  word_t                              wdata,
    input  logic [NUM_BANK-1:0][WORD_W-1:0]    pending,
    input  logic [NUM_BANK-1:0][WORD_W-1:0]    enable,
    output logic [NUM_DST-1:0][NUM_BANK-1:0][WORD_W-1:0] route_q,
    output logic [NUM_DST-1:0][NUM_BANK-1:0][WORD_W-1:0] ident,
    output logic [NUM_DST-1:0]                 dst_irq
);
    logic [NUM_DST-1:0] any_act;

    for (genvar n = 0; n < NUM_DST; n++) begin : g_dst
        logic [NUM_BANK-1:0] bank_act;
        for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
            localparam word_t VALID = bank_valid(b);
            always_ff @(posedge clk) begin
                if (rst)
                    route_q[n][b] <= '0;
                else if (map_we && map_bank == BANK_W'(b) && map_dst == DST_W'(n))
                    route_q[n][b] <= wdata & VALID;
            end
            assign ident[n][b] = pending[b] & enable[b] & route_q[n][b];
            assign bank_act[b] = |ident[n][b];
        end
        assign any_act[n] = |bank_act;
    end

    always_ff @(posedge clk) begin
        if (rst) dst_irq <= '0;
        else     dst_irq <= any_act;
    end

    assert_route_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !map_we |=> $stable(route_q));

    // with every enable off, no line may rise on the following edge (R7, R10)
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |=> (dst_irq == '0));
endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
    import irqagg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    src_irq,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic [NUM_DST-1:0]    dst_irq
);
    localparam int PAD_SRC = NUM_BANK * WORD_W;

    reg_sel_t sel;
    logic [PAD_SRC-1:0] src_pad;
    logic [NUM_BANK-1:0][WORD_W-1:0] pending, enable;
    logic [NUM_DST-1:0][NUM_BANK-1:0][WORD_W-1:0] route_q, ident;

    assign sel     = decode(bus_addr);
    assign src_pad = PAD_SRC'(src_irq);

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        logic hit;
        assign hit = bus_wr && (sel.bank == BANK_W'(b));
        irqagg_bank #(.BANK_IDX(b)) u_bank (
            .clk         (clk),
            .rst         (rst),
            .src_in      (src_pad[b*WORD_W +: WORD_W]),
            .pend_clr_we (hit && sel.kind == RK_PEND),
            .en_clr_we   (hit && sel.kind == RK_ENCL),
            .en_set_we   (hit && sel.kind == RK_ENST),
            .wdata       (bus_wdata),
            .pending     (pending[b]),
            .enable      (enable[b])
        );
    end

    irqagg_route u_route (
        .clk      (clk),
        .rst      (rst),
        .map_we   (bus_wr && sel.kind == RK_ROUT),
        .map_bank (sel.bank),
        .map_dst  (sel.dst),
        .wdata    (bus_wdata),
        .pending  (pending),
        .enable   (enable),
        .route_q  (route_q),
        .ident    (ident),
        .dst_irq  (dst_irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel.kind)
            RK_PEND: bus_rdata = pending[sel.bank];
            RK_ENRD: bus_rdata = enable[sel.bank];
            RK_ROUT: bus_rdata = route_q[sel.dst][sel.bank];
            RK_IDNT: bus_rdata = ident[sel.dst][sel.bank];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/irqagg_ctrl_tb.sv
module irqagg_ctrl_tb;
    logic        clk = 0;
    logic        rst;
    logic [85:0] src_irq;
    logic        bus_wr;
    logic [8:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [8:0]  dst_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_pend [3];
    logic [31:0] m_en   [3];
    logic [31:0] m_map  [9][3];
    logic [8:0]  m_dst;

    irqagg_ctrl u_dut (
        .clk(clk), .rst(rst), .src_irq(src_irq), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dst_irq(dst_irq)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] vmask(int b);
        return (b == 2) ? 32'h003F_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] m_read(logic [8:0] a);
        for (int b = 0; b < 3; b++) begin
            if (a == 9'h030 + 9'(4*b)) return m_pend[b];
            if (a == 9'h048 + 9'(4*b)) return m_en[b];
            for (int n = 0; n < 9; n++) begin
                if (a == 9'h078 + 9'(36*b + 4*n)) return m_map[n][b];
                if (a == 9'h0E4 + 9'(36*b + 4*n)) return m_pend[b] & m_en[b] & m_map[n][b];
            end
        end
        return 32'h0;
    endfunction

    function automatic string tag_of(logic [8:0] a);
        if (a >= 9'h030 && a <= 9'h038 && a[1:0] == 0) return "R2";
        if (a >= 9'h048 && a <= 9'h050 && a[1:0] == 0) return "R4";
        if (a >= 9'h078 && a <= 9'h0E0 && a[1:0] == 0) return "R5";
        if (a >= 9'h0E4 && a <= 9'h14C && a[1:0] == 0) return "R6";
        return "R9";
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 3; b++) begin
            m_pend[b] = 0; m_en[b] = 0;
            for (int n = 0; n < 9; n++) m_map[n][b] = 0;
        end
        m_dst = 0;
    endtask

    task automatic model_step(logic wr, logic [8:0] a, logic [31:0] d, logic [85:0] s);
        logic [95:0] sp;
        sp = {10'b0, s};
        for (int n = 0; n < 9; n++) begin
            logic hit;
            hit = 0;
            for (int b = 0; b < 3; b++)
                if ((m_pend[b] & m_en[b] & m_map[n][b]) != 0) hit = 1;
            m_dst[n] = hit;
        end
        for (int b = 0; b < 3; b++) begin
            logic [31:0] pc, ec, es;
            pc = (wr && a == 9'h030 + 9'(4*b)) ? d : 0;
            ec = (wr && a == 9'h054 + 9'(4*b)) ? d : 0;
            es = (wr && a == 9'h060 + 9'(4*b)) ? d : 0;
            m_pend[b] = ((m_pend[b] & ~pc) | sp[b*32 +: 32]) & vmask(b);
            m_en[b]   = ((m_en[b] & ~ec) | es) & vmask(b);
            for (int n = 0; n < 9; n++)
                if (wr && a == 9'h078 + 9'(36*b + 4*n)) m_map[n][b] = d & vmask(b);
        end
    endtask

    task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, model follows the edge, return at next negedge
    task automatic cyc(logic wr, logic [8:0] a, logic [31:0] d, logic [85:0] s);
        bus_wr = wr; bus_addr = a; bus_wdata = d; src_irq = s;
        @(posedge clk);
        model_step(wr, a, d, s);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_check(logic [8:0] a, string tag);
        bus_wr = 0; bus_addr = a; #1;
        check(bus_rdata, m_read(a), tag);
    endtask

    function automatic logic [8:0] rand_addr(int kind);
        int b, n;
        b = $urandom_range(0, 2);
        n = $urandom_range(0, 8);
        case (kind)
            0: return 9'h030 + 9'(4*b);
            1: return 9'h048 + 9'(4*b);
            2: return 9'h054 + 9'(4*b);
            3: return 9'h060 + 9'(4*b);
            4, 5: return 9'h078 + 9'(36*b + 4*n);
            6: return 9'h0E4 + 9'(36*b + 4*n);
            default: begin
                case ($urandom_range(0, 4))
                    0: return 9'h000;
                    1: return 9'h06C;
                    2: return 9'h150;
                    3: return 9'h032;
                    default: return 9'h1FC;
                endcase
            end
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D2C_3B4A));
        rst = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; src_irq = '1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        src_irq = 0;
        rst = 0;
        // R1: everything zero after reset
        check({23'b0, dst_irq}, 0, "R1");
        for (int b = 0; b < 3; b++) begin
            bus_addr = 9'h030 + 9'(4*b); #1; check(bus_rdata, 0, "R1");
            bus_addr = 9'h048 + 9'(4*b); #1; check(bus_rdata, 0, "R1");
            bus_addr = 9'h078 + 9'(36*b); #1; check(bus_rdata, 0, "R1");
        end

        // R2: latch and hold after the source drops
        cyc(0, 0, 0, 86'(1) << 40);
        cyc(0, 0, 0, 0);
        bus_addr = 9'h034; #1; check(bus_rdata, 32'h0000_0100, "R2");

        // R7: route src 40 to dst 3, enable it; line rises one edge after ident
        cyc(1, 9'h078 + 9'(36 + 12), 32'h0000_0100, 0);
        cyc(1, 9'h064, 32'h0000_0100, 0);
        check({23'b0, dst_irq}, 0, "R7");
        cyc(0, 0, 0, 0);
        check({23'b0, dst_irq}, 32'h8, "R7");
        bus_addr = 9'h0E4 + 9'(36 + 12); #1; check(bus_rdata, 32'h0000_0100, "R6");

        // R6: write to ident ignored
        cyc(1, 9'h0E4 + 9'(36 + 12), 32'h0, 0);
        bus_addr = 9'h0E4 + 9'(36 + 12); #1; check(bus_rdata, 32'h0000_0100, "R6");

        // R3: clear while source still high -> stays set
        cyc(1, 9'h034, 32'h0000_0100, 86'(1) << 40);
        bus_addr = 9'h034; #1; check(bus_rdata, 32'h0000_0100, "R3");
        cyc(1, 9'h034, 32'h0000_0000, 0);
        bus_addr = 9'h034; #1; check(bus_rdata, 32'h0000_0100, "R3");
        cyc(1, 9'h034, 32'h0000_0100, 0);
        bus_addr = 9'h034; #1; check(bus_rdata, 32'h0, "R3");
        cyc(0, 0, 0, 0);
        check({23'b0, dst_irq}, 0, "R7");

        // R4: write to enable readback ignored, clear leaves other bits
        cyc(1, 9'h048, 32'hFFFF_FFFF, 0);
        bus_addr = 9'h048; #1; check(bus_rdata, 0, "R4");
        cyc(1, 9'h060, 32'h0000_00F0, 0);
        cyc(1, 9'h054, 32'h0000_0030, 0);
        bus_addr = 9'h048; #1; check(bus_rdata, 32'h0000_00C0, "R4");

        // R8: unused top bits of bank 2
        cyc(1, 9'h068, 32'hFFFF_FFFF, '1);
        bus_addr = 9'h050; #1; check(bus_rdata, 32'h003F_FFFF, "R8");
        bus_addr = 9'h038; #1; check(bus_rdata, 32'h003F_FFFF, "R8");
        cyc(1, 9'h078 + 9'(72), 32'hFFFF_FFFF, 0);
        bus_addr = 9'h078 + 9'(72); #1; check(bus_rdata, 32'h003F_FFFF, "R8");

        // R9: unmapped and misaligned offsets
        cyc(1, 9'h07A, 32'hFFFF_FFFF, 0);
        bus_addr = 9'h078; #1; check(bus_rdata, m_read(9'h078), "R9");
        bus_addr = 9'h07A; #1; check(bus_rdata, 0, "R9");
        bus_addr = 9'h150; #1; check(bus_rdata, 0, "R9");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [85:0] s;
            logic [8:0]  a;
            int k;
            s = {22'($urandom() & $urandom() & $urandom()),
                 $urandom() & $urandom() & $urandom(),
                 $urandom() & $urandom() & $urandom()};
            if ($urandom_range(0, 3) == 0) s = 0;
            k = $urandom_range(0, 7);
            a = rand_addr(k);
            cyc($urandom_range(0, 4) != 0, a, $urandom(), s);
            check({23'b0, dst_irq}, {23'b0, m_dst}, "R7");
            a = rand_addr($urandom_range(0, 7));
            rd_check(a, tag_of(a));
        end

        // R10: disable all, acknowledge all, per bank
        for (int b = 0; b < 3; b++) cyc(1, 9'h054 + 9'(4*b), 32'hFFFF_FFFF, 0);
        for (int b = 0; b < 3; b++) cyc(1, 9'h030 + 9'(4*b), 32'hFFFF_FFFF, 0);
        cyc(0, 0, 0, 0);
        check({23'b0, dst_irq}, 0, "R10");
        for (int b = 0; b < 3; b++) begin
            bus_addr = 9'h030 + 9'(4*b); #1; check(bus_rdata, 0, "R10");
            bus_addr = 9'h048 + 9'(4*b); #1; check(bus_rdata, 0, "R10");
            bus_addr = 9'h0E4 + 9'(36*b); #1; check(bus_rdata, 0, "R10");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule